// File: doc/BRIEF.md
# Serial Seven-Tap Q15 FIR Filter with Offset-Binary Sample Path

This block low-pass filters a stream of 8-bit unsigned converter samples and returns 8-bit unsigned codes for a digital-to-analog converter. Each accepted sample is recentred around zero and widened to a signed Q15 word. It is pushed into a seven-word history, and a single multiplier then walks the history one tap per clock, summing the signed products into a 32-bit accumulator. The Q30 sum is doubled to Q31, and its top byte, with the sign bit flipped, is the output code.

The host offers samples with a valid strobe and sees a ready flag that stays low while a result is being computed. The seven coefficients sit in a small writable register file. It comes out of reset holding a symmetric low-pass set and can be rewritten between samples.

Top module: `fir_q15_filter`

## Requirements
- R1: After reset, sampleReady is 1, dacValid is 0, dacOut is 0x80, every history word is zero and the coefficient file holds 197, 1615, 5679, 8192, 5679, 1615, 197 for taps 0 through 6.
- R2: An accepted sample s becomes the signed 16-bit word whose upper byte is (s + 0x80) mod 256 (s with its top bit inverted) and whose lower byte is zero, so 0xFF maps to +32512, 0x80 to 0 and 0x00 to -32768.
- R3: Each accepted sample enters history position 0, every older word moves up one position, and the word in position 6 is discarded. Output n uses coefficient k times the sample accepted k samples earlier.
- R4: The accumulator starts from zero for every accepted sample, so a result depends only on the seven history words and the coefficients.
- R5: The result is the 32-bit wrapping sum of the seven signed 16x16 products, shifted left by one bit. dacOut is bits 31..24 of that value with bit 31 inverted.
- R6: dacValid is a one-cycle pulse that rises exactly 9 clock cycles after the edge that accepted the sample. dacOut changes only together with that pulse and holds its value otherwise.
- R7: sampleReady falls on the edge after an accepted sample and rises again in the cycle that dacValid pulses. A sample offered while sampleReady is low is ignored and leaves the history unchanged.
- R8: While sampleReady is high, coefWe with coefAddr in 0..6 loads coefData (signed Q15) into that tap's coefficient. A write to address 7 changes nothing.
- R9: A coefficient write presented while sampleReady is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Sample offered this cycle |
| sampleIn | input | 8 | Unsigned offset-binary sample |
| sampleReady | output | 1 | Block idle and able to take a sample |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 3 | Tap index for the coefficient write |
| coefData | input | 16 | Signed Q15 coefficient value |
| dacValid | output | 1 | One-cycle pulse marking a new output code |
| dacOut | output | 8 | Unsigned offset-binary output code |

## Verification
On every cycle the assertions check the following:
- the fixed nine-cycle gap between acceptance and dacValid, using a counter kept apart from the state machine;
- that dacValid is a single-cycle pulse and that dacOut holds between pulses;
- that ready drops after an accept;
- that the history and the coefficients do not move when no load or permitted write takes place;
- that the accumulator is cleared at every start.

The arithmetic needs the bench's scenarios to show it: the offset-binary conversion at both extremes of the input, the impulse walking out through each coefficient in turn, the wrapping Q30 to Q31 byte pick, and the outputs after coefficients are rewritten. The same holds for whether a rejected sample or a refused write really leaves later results unchanged.

// File: rtl/fir_q15_pkg.sv
package fir_q15_pkg;
  localparam int NUM_TAPS = 7;
  localparam int SEL_W    = $clog2(NUM_TAPS);

  typedef struct packed {
    logic             load;    // push the new sample into the history
    logic             clear;   // zero the accumulator
    logic             mac;     // add one product
    logic [SEL_W-1:0] tapSel;  // tap used by the multiplier
    logic             shift;   // Q30 to Q31
    logic             emit;    // register the output byte
  } fir_ctl_t;

  function automatic logic [15:0] defaultCoef(input int idx);
    case (idx)
      0, 6:    return 16'd197;
      1, 5:    return 16'd1615;
      2, 4:    return 16'd5679;
      3:       return 16'd8192;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_q15_pkg::*;
#(
  parameter int TAPS = NUM_TAPS
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleValid,
  output logic     sampleReady,
  output fir_ctl_t ctl,
  output logic     dacValid
);
  localparam int LATENCY = TAPS + 2;
  localparam int CNT_W   = $clog2(LATENCY + 2);

  typedef enum logic [1:0] {S_IDLE, S_MAC, S_SHIFT, S_EMIT} state_t;

  state_t           state;
  logic [SEL_W-1:0] tapCnt;
  logic             accept;

  assign sampleReady = (state == S_IDLE);
  assign accept      = sampleValid && sampleReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tapCnt   <= '0;
      dacValid <= 1'b0;
    end else begin
      dacValid <= (state == S_EMIT);
      case (state)
        S_IDLE: begin
          tapCnt <= '0;
          if (accept) state <= S_MAC;
        end
        S_MAC: begin
          if (tapCnt == SEL_W'(TAPS - 1)) begin
            state  <= S_SHIFT;
            tapCnt <= '0;
          end else begin
            tapCnt <= tapCnt + 1'b1;
          end
        end
        S_SHIFT: state <= S_EMIT;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.load   = accept;
    ctl.clear  = accept;
    ctl.mac    = (state == S_MAC);
    ctl.tapSel = tapCnt;
    ctl.shift  = (state == S_SHIFT);
    ctl.emit   = (state == S_EMIT);
  end

  // Independent latency tracker used only by the checks below.
  logic             latRun;
  logic [CNT_W-1:0] latCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latRun <= 1'b0;
      latCnt <= '0;
    end else if (accept) begin
      latRun <= 1'b1;
      latCnt <= '0;
    end else if (latRun && latCnt != CNT_W'(LATENCY + 1)) begin
      latCnt <= latCnt + 1'b1;
    end
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |-> (latRun && latCnt == CNT_W'(LATENCY)));
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |=> !dacValid);
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !sampleReady);
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_q15_pkg::*;
#(
  parameter int TAPS   = NUM_TAPS,
  parameter int IN_W   = 8,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fir_ctl_t                 ctl,
  input  logic [IN_W-1:0]          sampleIn,
  input  logic                     coefWe,
  input  logic [SEL_W-1:0]         coefAddr,
  input  logic [COEF_W-1:0]        coefData,
  input  logic                     wrOpen,
  output logic [IN_W-1:0]          dacOut
);
  localparam int PAD_W = COEF_W - IN_W;
  localparam int EXT_W = ACC_W - COEF_W;

  logic [TAPS-1:0][COEF_W-1:0] history;
  logic [TAPS-1:0][COEF_W-1:0] coefReg;
  logic [COEF_W-1:0]           newWord;
  logic [COEF_W-1:0]           coefSel;
  logic [COEF_W-1:0]           histSel;
  logic signed [ACC_W-1:0]     product;
  logic signed [ACC_W-1:0]     accR;

  // Offset binary to signed: invert the top bit, pad the low byte with zeros.
  assign newWord = {~sampleIn[IN_W-1], sampleIn[IN_W-2:0], {PAD_W{1'b0}}};

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        coefReg[i] <= COEF_W'(defaultCoef(i));
      else if (coefWe && wrOpen && coefAddr == SEL_W'(i))
        coefReg[i] <= coefData;
    end

    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         history[i] <= '0;
        else if (ctl.load) history[i] <= newWord;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         history[i] <= '0;
        else if (ctl.load) history[i] <= history[i-1];
      end
    end
  end

  always_comb begin
    coefSel = '0;
    histSel = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (ctl.tapSel == SEL_W'(i)) begin
        coefSel = coefReg[i];
        histSel = history[i];
      end
    end
  end

  assign product = $signed({{EXT_W{coefSel[COEF_W-1]}}, coefSel})
                 * $signed({{EXT_W{histSel[COEF_W-1]}}, histSel});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          accR <= '0;
    else if (ctl.clear) accR <= '0;
    else if (ctl.mac)   accR <= accR + product;
    else if (ctl.shift) accR <= accR <<< 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         dacOut <= {1'b1, {(IN_W-1){1'b0}}};
    else if (ctl.emit) dacOut <= {~accR[ACC_W-1], accR[ACC_W-2 -: IN_W-1]};
  end

  p_acc_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (accR == '0));
  p_line_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(history));
  p_coef_lock_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!coefWe || !wrOpen) |=> $stable(coefReg));
endmodule

// File: rtl/fir_q15_filter.sv
module fir_q15_filter
  import fir_q15_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [IN_W-1:0]   sampleIn,
  output logic              sampleReady,
  input  logic              coefWe,
  input  logic [SEL_W-1:0]  coefAddr,
  input  logic [COEF_W-1:0] coefData,
  output logic              dacValid,
  output logic [IN_W-1:0]   dacOut
);
  fir_ctl_t ctl;

  fir_ctrl #(.TAPS(NUM_TAPS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleReady(sampleReady),
    .ctl        (ctl),
    .dacValid   (dacValid)
  );

  fir_datapath #(
    .TAPS  (NUM_TAPS),
    .IN_W  (IN_W),
    .COEF_W(COEF_W),
    .ACC_W (ACC_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .sampleIn(sampleIn),
    .coefWe  (coefWe),
    .coefAddr(coefAddr),
    .coefData(coefData),
    .wrOpen  (sampleReady),
    .dacOut  (dacOut)
  );

  p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dacValid |-> $stable(dacOut));
endmodule

// File: tb/fir_q15_filter_bench.sv
module fir_q15_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [7:0]  sampleIn = '0;
  logic        sampleReady;
  logic        coefWe = 1'b0;
  logic [2:0]  coefAddr = '0;
  logic [15:0] coefData = '0;
  logic        dacValid;
  logic [7:0]  dacOut;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  int mdlCoef[7];
  int mdlHist[7];

  always #2.5 clk = ~clk;

  fir_q15_filter u_fir_q15_filter (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .sampleReady(sampleReady), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .dacValid(dacValid), .dacOut(dacOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    nVec++;
    if (actual != expected) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  function automatic logic [7:0] modelOut();
    logic [31:0] acc;
    acc = '0;
    for (int k = 0; k < 7; k++) acc = acc + 32'(mdlCoef[k] * mdlHist[k]);
    acc = acc << 1;
    return {~acc[31], acc[30:24]};
  endfunction

  function automatic void modelPush(input logic [7:0] s);
    logic signed [15:0] w;
    w = {~s[7], s[6:0], 8'h00};
    for (int k = 6; k > 0; k--) mdlHist[k] = mdlHist[k-1];
    mdlHist[0] = w;
  endfunction

  // mode 0: plain; 1: offer a second sample while busy; 2: coefficient write while busy
  task automatic runSample(input logic [7:0] s, input int mode, input string req);
    int cycles;
    logic [7:0] held;
    @(negedge clk);
    while (!sampleReady) @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = s;
    @(negedge clk);
    sampleValid = 1'b0;
    modelPush(s);
    cycles = 1;
    while (!dacValid && cycles < 40) begin
      if (mode == 1) begin
        check("R7 ready low while busy", sampleReady, 0);
        sampleValid = 1'b1;
        sampleIn    = 8'hFF;
      end
      if (mode == 2) begin
        coefWe   = (cycles == 2);
        coefAddr = 3'd0;
        coefData = 16'h7FFF;
      end
      @(negedge clk);
      cycles++;
    end
    sampleValid = 1'b0;
    coefWe      = 1'b0;
    check("R6 latency", cycles - 1, 9);
    check({req, " output code"}, dacOut, modelOut());
    if (mode == 1) check("R7 ready back with pulse", sampleReady, 1);
    held = dacOut;
    @(negedge clk);
    check("R6 single-cycle pulse", dacValid, 0);
    check("R6 output held", dacOut, held);
  endtask

  task automatic writeCoef(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!sampleReady) @(negedge clk);
    coefWe = 1'b1; coefAddr = a; coefData = d;
    @(negedge clk);
    coefWe = 1'b0;
    if (a < 3'd7) mdlCoef[a] = $signed(d);
  endtask

  task automatic testReset();
    check("R1 ready after reset", sampleReady, 1);
    check("R1 no valid after reset", dacValid, 0);
    check("R1 midscale output", dacOut, 8'h80);
  endtask

  task automatic testImpulse();
    // R3: a full-scale impulse walks through each default coefficient (R1), then drops out
    runSample(8'hFF, 0, "R2 R3 impulse tap0");
    for (int k = 1; k < 7; k++) runSample(8'h80, 0, "R3 impulse walk");
    runSample(8'h80, 0, "R3 impulse discarded");
    check("R3 zero after drop", dacOut, 8'h80);
  endtask

  task automatic testNegative();
    runSample(8'h00, 0, "R2 most negative input");
    runSample(8'h00, 0, "R2 negative pair");
    for (int k = 0; k < 6; k++) runSample(8'h80, 0, "R3 negative flush");
  endtask

  task automatic testPattern();
    logic [7:0] v = 8'h5A;
    for (int k = 0; k < 20; k++) begin
      v = v * 8'd37 + 8'd11;
      runSample(v, 0, "R4 R5 mixed stream");
    end
    for (int k = 0; k < 8; k++) runSample(8'hC0, 0, "R5 DC level");
  endtask

  task automatic testBusyReject();
    runSample(8'h20, 1, "R7 rejected sample");
    runSample(8'h80, 0, "R7 history untouched");
  endtask

  task automatic testCoefLoad();
    for (int k = 0; k < 7; k++) writeCoef(3'(k), 16'h0000);
    writeCoef(3'd3, 16'hC000);
    writeCoef(3'd7, 16'h4000);
    runSample(8'hFF, 0, "R8 single negative tap");
    runSample(8'hE0, 0, "R8 reloaded set");
    writeCoef(3'd0, 16'h7FFF);
    writeCoef(3'd6, 16'h8001);
    runSample(8'h90, 0, "R8 extreme coefficients");
    for (int k = 0; k < 6; k++) runSample(8'h40, 0, "R8 address 7 ignored");
  endtask

  task automatic testCoefBusy();
    writeCoef(3'd0, 16'h0100);
    runSample(8'hA0, 2, "R9 write during busy");
    runSample(8'hF0, 0, "R9 coefficient kept");
  endtask

  initial begin
    for (int k = 0; k < 7; k++) begin
      mdlCoef[k] = 0;
      mdlHist[k] = 0;
    end
    mdlCoef[0] = 197;  mdlCoef[1] = 1615; mdlCoef[2] = 5679; mdlCoef[3] = 8192;
    mdlCoef[4] = 5679; mdlCoef[5] = 1615; mdlCoef[6] = 197;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testImpulse();
    testNegative();
    testPattern();
    testBusyReject();
    testCoefLoad();
    testCoefBusy();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule